// File: doc/BRIEF.md
# Partitioned Transmit Buffer Controller

This block owns a single word-wide buffer memory shared by several IN endpoints and carves it into one circular FIFO per endpoint. Software programs a word count for every endpoint; the block lays the regions out back to back. The first region starts at word 0, and every later region begins where the previous one ends. A bus-side writer pushes words into a chosen endpoint's FIFO. A device-side reader pulls words out of a chosen endpoint's FIFO with one cycle of read latency.

Pushed words stay hidden from the reader until the writer confirms the transfer with a per-endpoint commit pulse. A per-endpoint abort pulse throws away everything pushed since the last commit. The block keeps sticky overflow and underflow flags and a configuration-error flag. Any attempt by the system bus to read the buffer is answered with an error response.

Top module: `txb_partition`

## Requirements
- R1: After reset every endpoint reports empty_o=1 and full_o=0, ovf_o, unf_o, cfg_err_o, rd_valid_o and bus_err_o are 0, and every region holds DEPTH/NUM_EP words.
- R2: Region i starts at the sum of the sizes of regions 0..i-1 (region 0 at word 0). With every FIFO filled to its size at once, each endpoint reads back exactly its own data.
- R3: Each endpoint returns words in the order they were pushed. Its pointers wrap from the last word of its region to the first, and it holds exactly `size` words.
- R4: Pushed words are not visible to the reader (empty_o stays 1 and they are not returned) until commit_i[ep] pulses. A commit publishes every word pushed before that cycle.
- R5: full_o[ep] is 1 when `size` words are held, counting words that are not yet committed. A push to a full FIFO is dropped and sets ovf_o[ep], which stays 1 until reset.
- R6: A read of an endpoint with no committed words returns rd_data_o=0 with rd_valid_o=1 and sets unf_o[ep], which stays 1 until reset.
- R7: abort_i[ep] (without commit_i[ep] in the same cycle) discards all words pushed since the last commit. A push in the same cycle as the abort is dropped.
- R8: A size write that changes endpoint k's size clears all pointers of endpoints k..NUM_EP-1, leaving endpoints below k untouched. A size write with the current value changes nothing.
- R9: cfg_err_o is 1 while the sum of all sizes exceeds DEPTH. While it is 1, pushes are dropped without storing data and without setting ovf_o.
- R10: bus_rd_i=1 produces bus_err_o=1 in the next cycle and never returns buffer data; bus_err_o is 0 in the cycle after a cycle with bus_rd_i=0.
- R11: rd_valid_o is 1 exactly one cycle after a cycle with rd_en_i=1, with the returned word on rd_data_o in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Size register write strobe |
| cfg_ep_i | input | EPW | Endpoint whose size is written |
| cfg_size_i | input | SZW | New region size in words |
| cfg_err_o | output | 1 | Sum of sizes exceeds memory depth |
| wr_en_i | input | 1 | Push strobe |
| wr_ep_i | input | EPW | Endpoint pushed to |
| wr_data_i | input | DATA_W | Word pushed |
| commit_i | input | NUM_EP | Per-endpoint transfer confirmation pulse |
| abort_i | input | NUM_EP | Per-endpoint discard-uncommitted pulse |
| rd_en_i | input | 1 | Pop strobe |
| rd_ep_i | input | EPW | Endpoint popped from |
| rd_valid_o | output | 1 | Pop result valid (one cycle after rd_en_i) |
| rd_data_o | output | DATA_W | Popped word, 0 on underflow |
| bus_rd_i | input | 1 | System bus read of the buffer region |
| bus_err_o | output | 1 | Error response for a bus read |
| full_o | output | NUM_EP | Endpoint FIFO full (writer view) |
| empty_o | output | NUM_EP | No committed word available (reader view) |
| ovf_o | output | NUM_EP | Sticky push-while-full flag |
| unf_o | output | NUM_EP | Sticky pop-while-empty flag |

## Verification
The bench builds the block with NUM_EP=4 and DEPTH=64, so each default region holds 16 words. At that depth, a full wrap, a completely full FIFO and a sum of sizes just above the memory depth all take only tens of cycles. The bench also resizes the regions to 8, 20, 4 and 30 words. With these unequal sizes a wrong running-sum base shows up as one endpoint's words appearing in another's read stream.

// File: rtl/txb_pkg.sv
package txb_pkg;

  // Selects the next value of an endpoint's working write pointer.
  typedef enum logic [1:0] {
    WK_HOLD   = 2'd0,
    WK_CLEAR  = 2'd1,
    WK_REWIND = 2'd2,
    WK_STEP   = 2'd3
  } wk_act_e;

  // Index width for a count of items, never below one bit.
  function automatic int unsigned idx_bits(input int unsigned count);
    return (count < 2) ? 1 : $clog2(count);
  endfunction

endpackage

// File: rtl/txb_mem.sv
module txb_mem #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 10
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] store_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) store_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_q <= store_q[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/txb_layout.sv
module txb_layout
  import txb_pkg::*;
#(
  parameter int unsigned NUM_EP = 4,
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned SZW    = 11,
  parameter int unsigned EPW    = 2,
  parameter int unsigned SUMW   = 13
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_wr_i,
  input  logic [EPW-1:0]                 cfg_ep_i,
  input  logic [SZW-1:0]                 cfg_size_i,
  output logic [NUM_EP-1:0][SZW-1:0]     size_o,
  output logic [NUM_EP-1:0][SUMW-1:0]    base_o,
  output logic [NUM_EP-1:0]              clr_o,
  output logic                           cfg_err_o
);

  localparam int unsigned RST_SIZE = DEPTH / NUM_EP;

  logic [NUM_EP-1:0][SZW-1:0]  size_q, size_d;
  logic [NUM_EP-1:0][SUMW-1:0] base_c;
  logic [SUMW-1:0]             total_c;
  logic                        ep_ok;
  logic                        size_en;
  logic                        size_changed;

  assign ep_ok        = int'(cfg_ep_i) < int'(NUM_EP);
  assign size_en      = cfg_wr_i && ep_ok;
  assign size_changed = size_en && (cfg_size_i != size_q[cfg_ep_i]);

  // Next-state of the size registers.
  always_comb begin
    size_d = size_q;
    if (size_en) size_d[cfg_ep_i] = cfg_size_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= {NUM_EP{SZW'(RST_SIZE)}};
    end else if (size_en) begin
      size_q <= size_d;
    end
  end

  // Running sum: each region begins where the previous one ends.
  always_comb begin
    logic [SUMW-1:0] acc;
    acc = '0;
    for (int i = 0; i < int'(NUM_EP); i++) begin
      base_c[i] = acc;
      acc       = acc + SUMW'(size_q[i]);
    end
    total_c = acc;
  end

  // A changed size moves this region and every later one.
  for (genvar g = 0; g < int'(NUM_EP); g++) begin : g_clr
    assign clr_o[g] = size_changed && (int'(cfg_ep_i) <= g);
  end

  assign size_o    = size_q;
  assign base_o    = base_c;
  assign cfg_err_o = total_c > SUMW'(DEPTH);

  // R8: a size write lands in the addressed register.
  p_size_written_r8: assert property (@(posedge clk) disable iff (!rst_n)
    size_en |=> (size_q[$past(cfg_ep_i)] == $past(cfg_size_i)));

endmodule

// File: rtl/txb_ep_ptrs.sv
module txb_ep_ptrs
  import txb_pkg::*;
#(
  parameter int unsigned SZW = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SZW-1:0] size_i,
  input  logic           clr_i,
  input  logic           wr_go_i,
  input  logic           rd_go_i,
  input  logic           commit_i,
  input  logic           abort_i,
  output logic [SZW-1:0] wr_off_o,
  output logic [SZW-1:0] rd_off_o,
  output logic           full_o,
  output logic           empty_o
);

  localparam int unsigned PW = SZW + 1;  // offset plus wrap bit

  logic [PW-1:0] wk_q, wk_d;   // working write pointer
  logic [PW-1:0] cm_q, cm_d;   // committed write pointer
  logic [PW-1:0] rd_q, rd_d;   // read pointer
  logic          wk_en, cm_en, rd_en;
  logic          zero_size;
  wk_act_e       wk_act;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p,
                                             input logic [SZW-1:0] sz);
    logic [SZW-1:0] off;
    off = p[SZW-1:0];
    if (off == sz - SZW'(1)) return {~p[PW-1], {SZW{1'b0}}};
    return {p[PW-1], off + SZW'(1)};
  endfunction

  // Working pointer: clear beats abort, abort beats a push; commit cancels abort.
  always_comb begin
    if (clr_i)                     wk_act = WK_CLEAR;
    else if (abort_i && !commit_i) wk_act = WK_REWIND;
    else if (wr_go_i)              wk_act = WK_STEP;
    else                           wk_act = WK_HOLD;
  end

  always_comb begin
    case (wk_act)
      WK_CLEAR:  wk_d = '0;
      WK_REWIND: wk_d = cm_q;
      WK_STEP:   wk_d = step_ptr(wk_q, size_i);
      default:   wk_d = wk_q;
    endcase
    cm_d  = clr_i ? '0 : wk_q;
    rd_d  = clr_i ? '0 : step_ptr(rd_q, size_i);
    wk_en = (wk_act != WK_HOLD);
    cm_en = clr_i || commit_i;
    rd_en = clr_i || rd_go_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_q <= '0;
    end else if (wk_en) begin
      wk_q <= wk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_q <= '0;
    end else if (cm_en) begin
      cm_q <= cm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign zero_size = (size_i == '0);
  assign wr_off_o  = wk_q[SZW-1:0];
  assign rd_off_o  = rd_q[SZW-1:0];
  assign full_o    = zero_size ||
                     ((wk_q[SZW-1:0] == rd_q[SZW-1:0]) && (wk_q[PW-1] != rd_q[PW-1]));
  assign empty_o   = zero_size || (cm_q == rd_q);

  // R4: data only becomes visible to the reader through a commit.
  p_empty_needs_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty_o) |-> $past(commit_i));

  // R3: the read offset stays inside the region.
  p_rd_in_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i != '0) |-> (rd_q[SZW-1:0] < size_i));

endmodule

// File: rtl/txb_partition.sv
module txb_partition
  import txb_pkg::*;
#(
  parameter  int unsigned NUM_EP = 4,
  parameter  int unsigned DEPTH  = 1024,
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned EPW    = idx_bits(NUM_EP),
  localparam int unsigned SZW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic [EPW-1:0]    cfg_ep_i,
  input  logic [SZW-1:0]    cfg_size_i,
  output logic              cfg_err_o,
  input  logic              wr_en_i,
  input  logic [EPW-1:0]    wr_ep_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NUM_EP-1:0] commit_i,
  input  logic [NUM_EP-1:0] abort_i,
  input  logic              rd_en_i,
  input  logic [EPW-1:0]    rd_ep_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              bus_rd_i,
  output logic              bus_err_o,
  output logic [NUM_EP-1:0] full_o,
  output logic [NUM_EP-1:0] empty_o,
  output logic [NUM_EP-1:0] ovf_o,
  output logic [NUM_EP-1:0] unf_o
);

  localparam int unsigned AW   = idx_bits(DEPTH);
  localparam int unsigned SUMW = $clog2(NUM_EP * DEPTH + 1);

  logic [NUM_EP-1:0][SZW-1:0]  size_w;
  logic [NUM_EP-1:0][SUMW-1:0] base_w;
  logic [NUM_EP-1:0][SZW-1:0]  wr_off_w, rd_off_w;
  logic [NUM_EP-1:0]           clr_w;
  logic [NUM_EP-1:0]           wsel, rsel, wr_go, rd_go;
  logic [NUM_EP-1:0]           ovf_q, ovf_d, unf_q, unf_d;
  logic                        flag_en;
  logic                        wr_ok, rd_ok;
  logic [SUMW-1:0]             wsum, rsum;
  logic                        mem_we, mem_re;
  logic [DATA_W-1:0]           mem_rdata;
  logic                        rd_valid_q, rd_zero_q, bus_err_q;

  assign wr_ok = int'(wr_ep_i) < int'(NUM_EP);
  assign rd_ok = int'(rd_ep_i) < int'(NUM_EP);

  txb_layout #(
    .NUM_EP (NUM_EP),
    .DEPTH  (DEPTH),
    .SZW    (SZW),
    .EPW    (EPW),
    .SUMW   (SUMW)
  ) u_layout (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_ep_i   (cfg_ep_i),
    .cfg_size_i (cfg_size_i),
    .size_o     (size_w),
    .base_o     (base_w),
    .clr_o      (clr_w),
    .cfg_err_o  (cfg_err_o)
  );

  for (genvar g = 0; g < int'(NUM_EP); g++) begin : g_ep
    assign wsel[g]  = wr_en_i && wr_ok && (int'(wr_ep_i) == g);
    assign rsel[g]  = rd_en_i && rd_ok && (int'(rd_ep_i) == g);
    assign wr_go[g] = wsel[g] && !full_o[g] && !cfg_err_o && !abort_i[g] && !clr_w[g];
    assign rd_go[g] = rsel[g] && !empty_o[g];
    assign ovf_d[g] = ovf_q[g] || (wsel[g] && full_o[g] && !cfg_err_o &&
                                   !abort_i[g] && !clr_w[g]);
    assign unf_d[g] = unf_q[g] || (rsel[g] && empty_o[g]);

    txb_ep_ptrs #(
      .SZW (SZW)
    ) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .size_i   (size_w[g]),
      .clr_i    (clr_w[g]),
      .wr_go_i  (wr_go[g]),
      .rd_go_i  (rd_go[g]),
      .commit_i (commit_i[g]),
      .abort_i  (abort_i[g]),
      .wr_off_o (wr_off_w[g]),
      .rd_off_o (rd_off_w[g]),
      .full_o   (full_o[g]),
      .empty_o  (empty_o[g])
    );

    // R5: overflow is sticky.
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q[g] |=> ovf_q[g]);

    // R9: a configuration error freezes the working write pointer.
    p_err_freezes_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err_o && !clr_w[g] && !abort_i[g]) |=> (wr_off_w[g] == $past(wr_off_w[g])));
  end

  // Address of the pushed or popped word: region base plus offset.
  always_comb begin
    wsum = '0;
    rsum = '0;
    for (int i = 0; i < int'(NUM_EP); i++) begin
      if (int'(wr_ep_i) == i) wsum = base_w[i] + SUMW'(wr_off_w[i]);
      if (int'(rd_ep_i) == i) rsum = base_w[i] + SUMW'(rd_off_w[i]);
    end
  end

  assign mem_we  = |wr_go;
  assign mem_re  = |rd_go;
  assign flag_en = (|wsel) || (|rsel);

  txb_mem #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .AW     (AW)
  ) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (wsum[AW-1:0]),
    .wdata_i (wr_data_i),
    .re_i    (mem_re),
    .raddr_i (rsum[AW-1:0]),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      unf_q <= '0;
    end else if (flag_en) begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_zero_q  <= 1'b1;
      bus_err_q  <= 1'b0;
    end else begin
      rd_valid_q <= rd_en_i;
      rd_zero_q  <= !mem_re;
      bus_err_q  <= bus_rd_i;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_zero_q ? '0 : mem_rdata;
  assign bus_err_o  = bus_err_q;
  assign ovf_o      = ovf_q;
  assign unf_o      = unf_q;

  // R10: every bus read of the buffer is answered with an error.
  p_bus_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_i |=> bus_err_o);

  // R6: a pop of an empty endpoint returns zero and flags underflow.
  p_underflow_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_ok && empty_o[rd_ep_i]) |=>
      (rd_valid_o && (rd_data_o == '0) && unf_o[$past(rd_ep_i)]));

  // R11: read result appears one cycle after the request.
  p_rd_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);

endmodule

// File: tb/txb_partition_bench.sv
module txb_partition_bench;

  localparam int NEP = 4;
  localparam int DEP = 64;
  localparam int DW  = 32;
  localparam int EPW = 2;
  localparam int SZW = $clog2(DEP + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_wr = 1'b0;
  logic [EPW-1:0] cfg_ep = '0;
  logic [SZW-1:0] cfg_size = '0;
  logic           cfg_err;
  logic           wr_en = 1'b0;
  logic [EPW-1:0] wr_ep = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [NEP-1:0] commit = '0;
  logic [NEP-1:0] abort = '0;
  logic           rd_en = 1'b0;
  logic [EPW-1:0] rd_ep = '0;
  logic           rd_valid;
  logic [DW-1:0]  rd_data;
  logic           bus_rd = 1'b0;
  logic           bus_err;
  logic [NEP-1:0] full, empty, ovf, unf;

  int tests = 0;
  int fails = 0;

  // Reference model of every endpoint FIFO.
  logic [DW-1:0] m_store [NEP][DEP];
  int            m_size [NEP];
  int            m_rd   [NEP];
  int            m_wrk  [NEP];
  int            m_cmt  [NEP];
  logic [NEP-1:0] m_ovf = '0;
  logic [NEP-1:0] m_unf = '0;
  logic           m_err = 1'b0;

  // Scoreboard of expected read results.
  logic [DW-1:0] exp_q [$];
  string         exp_tag [$];

  always #10ns clk = ~clk;  // 50 MHz

  txb_partition #(
    .NUM_EP (NEP),
    .DEPTH  (DEP),
    .DATA_W (DW)
  ) u_txb_partition (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_i   (cfg_wr),
    .cfg_ep_i   (cfg_ep),
    .cfg_size_i (cfg_size),
    .cfg_err_o  (cfg_err),
    .wr_en_i    (wr_en),
    .wr_ep_i    (wr_ep),
    .wr_data_i  (wr_data),
    .commit_i   (commit),
    .abort_i    (abort),
    .rd_en_i    (rd_en),
    .rd_ep_i    (rd_ep),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data),
    .bus_rd_i   (bus_rd),
    .bus_err_o  (bus_err),
    .full_o     (full),
    .empty_o    (empty),
    .ovf_o      (ovf),
    .unf_o      (unf)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever the design returns a word.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected rd_valid", 64'(rd_data), 64'(0));
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk(rd_data == e, t, 64'(rd_data), 64'(e));
      end
    end
  end

  task automatic check_flags(input string tag);
    logic [NEP-1:0] ef, ee;
    for (int j = 0; j < NEP; j++) begin
      ef[j] = (m_wrk[j] == m_size[j]);
      ee[j] = (m_cmt[j] == 0);
    end
    chk(full == ef, {tag, " full"}, 64'(full), 64'(ef));
    chk(empty == ee, {tag, " empty"}, 64'(empty), 64'(ee));
    chk(ovf == m_ovf, {tag, " ovf"}, 64'(ovf), 64'(m_ovf));
    chk(unf == m_unf, {tag, " unf"}, 64'(unf), 64'(m_unf));
    chk(cfg_err == m_err, {tag, " cfg_err"}, 64'(cfg_err), 64'(m_err));
  endtask

  task automatic do_write(input int ep, input logic [DW-1:0] d);
    if (!m_err) begin
      if (m_wrk[ep] == m_size[ep]) begin
        m_ovf[ep] = 1'b1;
      end else begin
        m_store[ep][(m_rd[ep] + m_wrk[ep]) % m_size[ep]] = d;
        m_wrk[ep]++;
      end
    end
    wr_en = 1'b1; wr_ep = EPW'(ep); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_commit(input int ep);
    m_cmt[ep] = m_wrk[ep];
    commit[ep] = 1'b1;
    @(negedge clk);
    commit = '0;
  endtask

  task automatic do_abort(input int ep);
    m_wrk[ep] = m_cmt[ep];
    abort[ep] = 1'b1;
    @(negedge clk);
    abort = '0;
  endtask

  task automatic do_read(input int ep, input string tag);
    if (m_cmt[ep] == 0) begin
      m_unf[ep] = 1'b1;
      exp_q.push_back('0);
    end else begin
      exp_q.push_back(m_store[ep][m_rd[ep]]);
      m_rd[ep] = (m_rd[ep] + 1) % m_size[ep];
      m_cmt[ep]--;
      m_wrk[ep]--;
    end
    exp_tag.push_back(tag);
    rd_en = 1'b1; rd_ep = EPW'(ep);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_cfg(input int ep, input int sz);
    int sum;
    if (sz != m_size[ep]) begin
      for (int j = ep; j < NEP; j++) begin
        m_rd[j] = 0; m_wrk[j] = 0; m_cmt[j] = 0;
      end
    end
    m_size[ep] = sz;
    sum = 0;
    for (int j = 0; j < NEP; j++) sum += m_size[j];
    m_err = (sum > DEP);
    cfg_wr = 1'b1; cfg_ep = EPW'(ep); cfg_size = SZW'(sz);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int j = 0; j < NEP; j++) begin
      m_size[j] = DEP / NEP; m_rd[j] = 0; m_wrk[j] = 0; m_cmt[j] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_flags("R1");
    chk(rd_valid == 1'b0, "R1 rd_valid", 64'(rd_valid), 64'(0));
    chk(bus_err == 1'b0, "R1 bus_err", 64'(bus_err), 64'(0));

    // R4: hidden until commit
    for (int k = 0; k < 3; k++) do_write(1, 32'h1100 + 32'(k));
    chk(empty[1] == 1'b1, "R4 empty before commit", 64'(empty[1]), 64'(1));
    do_read(1, "R4 read before commit");
    do_commit(1);
    check_flags("R4");
    for (int k = 0; k < 3; k++) do_read(1, "R4 data after commit");
    idle(2);

    // R3: order and wrap on a 16-word region
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 10; k++) do_write(2, 32'h2000 + 32'(r * 16 + k));
      do_commit(2);
      for (int k = 0; k < 10; k++) do_read(2, "R3 order/wrap");
    end
    idle(2);
    check_flags("R3");

    // R5: full and dropped push
    for (int k = 0; k < 16; k++) do_write(0, 32'h3000 + 32'(k));
    check_flags("R5 full uncommitted");
    do_write(0, 32'hDEAD0000);
    do_commit(0);
    check_flags("R5 overflow");
    for (int k = 0; k < 16; k++) do_read(0, "R5 data");
    idle(2);
    check_flags("R5 drained");

    // R8: resize clears only the resized and later regions
    do_write(0, 32'h4000); do_write(0, 32'h4001); do_commit(0);
    do_write(3, 32'h4300); do_commit(3);
    do_cfg(2, 4);
    check_flags("R8 resize ep2");
    do_read(0, "R8 lower endpoint kept"); do_read(0, "R8 lower endpoint kept");
    do_read(3, "R8 later endpoint cleared");
    do_cfg(0, 8); do_cfg(1, 20); do_cfg(3, 30);
    do_write(1, 32'h4100); do_commit(1);
    do_cfg(1, 20);
    check_flags("R8 same-value write");
    do_read(1, "R8 same-value keeps data");
    idle(2);

    // R2: all regions full at once with unequal sizes
    for (int e = 0; e < NEP; e++) begin
      for (int k = 0; k < m_size[e]; k++) do_write(e, 32'hA000_0000 + 32'(e << 8) + 32'(k));
      do_commit(e);
    end
    check_flags("R2 all full");
    for (int k = 0; k < 30; k++) begin
      for (int e = 0; e < NEP; e++) begin
        if (m_cmt[e] > 0) do_read(e, "R2 region isolation");
      end
    end
    idle(2);
    check_flags("R2 drained");

    // R6: underflow returns zero
    do_read(2, "R6 underflow data");
    idle(1);
    check_flags("R6");

    // R7: abort discards the unconfirmed packet
    do_write(1, 32'h7000); do_write(1, 32'h7001); do_commit(1);
    do_write(1, 32'h7002); do_write(1, 32'h7003); do_write(1, 32'h7004);
    do_abort(1);
    do_write(1, 32'h7005); do_commit(1);
    check_flags("R7");
    for (int k = 0; k < 3; k++) do_read(1, "R7 after abort");
    idle(2);
    check_flags("R7 drained");

    // R9: oversubscribed layout blocks pushes
    do_cfg(3, 64);
    check_flags("R9 cfg_err set");
    do_write(0, 32'h9000);
    do_commit(0);
    check_flags("R9 push dropped");
    do_cfg(3, 30);
    check_flags("R9 cfg_err cleared");
    do_read(0, "R9 nothing stored");
    idle(2);

    // R10: bus read answered with error
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_err == 1'b1, "R10 error response", 64'(bus_err), 64'(1));
    @(negedge clk);
    chk(bus_err == 1'b0, "R10 single pulse", 64'(bus_err), 64'(0));

    // R11: every issued read produced exactly one result
    idle(3);
    chk(exp_q.size() == 0, "R11 all results returned", 64'(exp_q.size()), 64'(0));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule